// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. It is given a starting column, a 3-bit burst length code and an ordering select, all held in the controller's mode configuration. A one-cycle start strobe captures these values. From the next cycle on, the block drives one column address per clock and raises a flag on the final beat.

Two orderings are supported. Sequential ordering wraps inside the aligned block of N columns. Interleaved ordering XORs the beat index into the low bits of the start column. A full-page length walks the whole column range and keeps going until a terminate request arrives. A new start strobe may arrive on any cycle, and it restarts the sequence at once, so bursts can run back to back with no idle cycle. The command sequencer owns command generation, the data path and bank or row tracking.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `colValid` and `lastBeat` are 0 and `colOut` is 0.
- R2: When `startIn` is sampled high on a clock edge, the cycle after that edge shows `colValid`=1 and `colOut` equal to the sampled `startCol`. This also applies during a running burst, which is then abandoned.
- R3: Burst length codes are 000=1, 001=2, 010=4, 011=8 and 111=full page. Codes 100, 101 and 110 act as length 1. `lastBeat` is high on beat N of an N-beat burst and only then. When the last beat is shown and no start is sampled, `colValid` is 0 in the next cycle. A length-1 burst shows `lastBeat` together with its single beat.
- R4: In sequential mode, beat k (counting from 0) outputs the start column with its low log2(N) bits replaced by (low bits + k) mod N. The upper bits stay unchanged.
- R5: In interleaved mode (`interleave`=1), beat k outputs the start column with its low log2(N) bits XORed with k.
- R6: In full-page mode, beat k outputs (start column + k) mod 2^COL_W, so the address wraps from the top column to 0. `interleave` has no effect in this mode, and `lastBeat` is never raised.
- R7: When `stopIn` is sampled high without `startIn`, `colValid` is 0 in the next cycle. `stopIn` while idle has no effect. When `startIn` and `stopIn` are high in the same cycle, the start wins.
- R8: `startCol`, `lenCode` and `interleave` are read only in a start cycle. Changing them during a burst does not alter its addresses, its length or its ordering.
- R9: Whenever `colValid` is 0, `colOut` is 0.
- R10: When a start is sampled in the cycle that shows `lastBeat`, the new burst's first beat follows in the next cycle with no gap in `colValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Begin a burst; captures the configuration |
| startCol | input | COL_W | First column of the burst |
| lenCode | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved ordering, 0 sequential |
| stopIn | input | 1 | Terminate the running burst |
| colOut | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A beat is being shown this cycle |
| lastBeat | output | 1 | The current beat is the final one of the burst |

## Verification
The assertions assume that `startIn` and `stopIn` are two-state values, sampled only at rising edges, and that `startCol` is stable around the edge at which a start is taken. They also assume nothing about burst length. This is why the stop, last-beat and restart properties are written only in terms of strobes and flags. The bench meets these conditions by changing every input on the falling edge. Start and stop are drawn from a seeded `$urandom` at low rates, so that bursts of all lengths, including long full-page runs, can finish, be cut short or be restarted. Directed cases cover the page wrap, the reserved length codes, start colliding with stop, and configuration changes in the middle of a burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic load;     // capture configuration, beat index to zero
    logic advance;  // step to the next beat
    logic active;   // a beat is being shown
  } colStrobe_t;

  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;

  // Number of low column bits that take part in the wrap; reserved codes give 0
  function automatic logic [1:0] lenBits(input logic [2:0] code);
    case (code)
      LEN_TWO:   lenBits = 2'd1;
      LEN_FOUR:  lenBits = 2'd2;
      LEN_EIGHT: lenBits = 2'd3;
      default:   lenBits = 2'd0;
    endcase
  endfunction

  function automatic logic isPageLen(input logic [2:0] code);
    isPageLen = (code == LEN_PAGE);
  endfunction

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       stopIn,
  input  logic       atLast,
  output colStrobe_t strobe,
  output logic       colValid,
  output logic       lastBeat
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state, stateNext;
  logic       running;

  assign running = (state == ST_RUN);

  // Start has priority; otherwise stop or the last beat end the burst
  always_comb begin
    stateNext = state;
    if (startIn)
      stateNext = ST_RUN;
    else if (running && (stopIn || atLast))
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.load    = startIn;
    strobe.advance = running && !startIn && !stopIn && !atLast;
    strobe.active  = running;
  end

  assign colValid = running;
  assign lastBeat = running && atLast;

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colOut,
  output logic             atLast
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatIdx;
  logic [COL_W-1:0] lowMask;
  logic             ilMode;
  logic             pageMode;

  logic [COL_W-1:0] maskNext;
  logic [1:0]       bitsNext;
  logic             pageNext;

  assign bitsNext = lenBits(lenCode);
  assign pageNext = isPageLen(lenCode);

  // One mask bit per column bit: set when that bit wraps within the burst
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign maskNext[i] = pageNext || (i < int'(bitsNext));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol  <= '0;
      beatIdx  <= '0;
      lowMask  <= '0;
      ilMode   <= 1'b0;
      pageMode <= 1'b0;
    end else if (strobe.load) begin
      baseCol  <= startCol;
      beatIdx  <= '0;
      lowMask  <= maskNext;
      ilMode   <= interleave && !pageNext;
      pageMode <= pageNext;
    end else if (strobe.advance) begin
      beatIdx  <= beatIdx + 1'b1;
    end
  end

  logic [COL_W-1:0] seqLow;
  logic [COL_W-1:0] xorLow;
  logic [COL_W-1:0] rawCol;

  always_comb begin
    seqLow = (baseCol + beatIdx) & lowMask;
    xorLow = (baseCol ^ beatIdx) & lowMask;
    rawCol = (baseCol & ~lowMask) | (ilMode ? xorLow : seqLow);
  end

  assign colOut = strobe.active ? rawCol : '0;
  assign atLast = !pageMode && (beatIdx == lowMask);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic             stopIn,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat
);

  colStrobe_t strobe;
  logic       atLast;

  burst_col_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .stopIn   (stopIn),
    .atLast   (atLast),
    .strobe   (strobe),
    .colValid (colValid),
    .lastBeat (lastBeat)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startCol   (startCol),
    .lenCode    (lenCode),
    .interleave (interleave),
    .colOut     (colOut),
    .atLast     (atLast)
  );

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [COL_W-1:0] startCol,
  input logic             stopIn,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             lastBeat
);

  a_r3_last_has_valid: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  a_r3_last_ends_burst: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && !startIn |=> !colValid);

  a_r2_start_loads_col: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> colValid && (colOut == $past(startCol)));

  a_r7_stop_ends_burst: assert property (@(posedge clk) disable iff (!rstN)
    stopIn && !startIn |=> !colValid);

  a_r9_idle_col_zero: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |-> (colOut == '0));

  a_r1_idle_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    !colValid && !startIn |=> !colValid);

  a_r10_no_gap_restart: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && startIn |=> colValid);

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startIn  (startIn),
  .startCol (startCol),
  .stopIn   (stopIn),
  .colOut   (colOut),
  .colValid (colValid),
  .lastBeat (lastBeat)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startIn = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = '0;
  logic             interleave = 1'b0;
  logic             stopIn = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             colValid;
  logic             lastBeat;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .stopIn(stopIn),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state
  bit mAct = 0;
  int mBase = 0, mK = 0, mN = 1;
  bit mIl = 0, mPage = 0;

  function automatic int codeLen(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int expCol();
    int hi, lo;
    if (mPage) return (mBase + mK) % PAGE;
    hi = mBase - (mBase % mN);
    lo = mBase % mN;
    if (mIl) return hi + (lo ^ mK);
    return hi + ((lo + mK) % mN);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOut();
    string tag;
    if (!mAct)      tag = "R9";
    else if (mPage) tag = "R6";
    else if (mIl)   tag = "R5";
    else            tag = "R4";
    check(tag, colValid, mAct);
    check(tag, colOut, mAct ? expCol() : 0);
    check("R3", lastBeat, (mAct && !mPage && mK == mN - 1) ? 1 : 0);
  endtask

  // Drive one cycle of inputs (at a falling edge), advance the model, check after the edge
  task automatic cycle(input bit st, input int col, input int len, input bit il, input bit sp);
    startIn = st; startCol = COL_W'(col); lenCode = 3'(len); interleave = il; stopIn = sp;
    if (st) begin
      mAct = 1; mBase = col; mK = 0; mPage = (len == 7);
      mN = codeLen(len); mIl = il && !mPage;
    end else if (mAct) begin
      if (sp || (!mPage && mK == mN - 1)) mAct = 0;
      else mK = (mK + 1) % PAGE;
    end
    @(posedge clk);
    @(negedge clk);
    checkOut();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R1: reset state
    check("R1", colValid, 0);
    check("R1", lastBeat, 0);
    check("R1", colOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2: start loads the column
    cycle(1, 37, 3, 0, 0);
    check("R2", colOut, 37);
    cycle(0, 0, 0, 0, 0);
    // R2: restart in mid burst
    cycle(1, 200, 2, 1, 0);
    check("R2", colOut, 200);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 0);

    // R5: interleaved length 8 from 13 -> 13,12,15,14,9,8,11,10
    cycle(1, 13, 3, 1, 0);
    for (int i = 0; i < 7; i++) cycle(0, 0, 0, 0, 0);
    check("R5", colOut, 10);
    cycle(0, 0, 0, 0, 0);

    // R3: reserved code acts as length 1
    cycle(1, 77, 5, 0, 0);
    check("R3", lastBeat, 1);
    cycle(0, 0, 0, 0, 0);
    check("R3", colValid, 0);

    // R6: full page wraps, interleave ignored
    cycle(1, PAGE - 2, 7, 1, 0);
    cycle(0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    check("R6", colOut, 0);
    for (int i = 0; i < 20; i++) cycle(0, 0, 0, 0, 0);
    check("R6", colValid, 1);
    // R7: stop ends it
    cycle(0, 0, 0, 0, 1);
    check("R7", colValid, 0);
    cycle(0, 0, 0, 0, 1);
    check("R7", colValid, 0);
    // R7: start wins over stop
    cycle(1, 9, 2, 0, 1);
    check("R7", colValid, 1);
    check("R7", colOut, 9);

    // R10: start in last-beat cycle
    cycle(1, 5, 1, 0, 0);
    cycle(0, 0, 0, 0, 0);
    check("R10", lastBeat, 1);
    cycle(1, 100, 0, 0, 0);
    check("R10", colValid, 1);
    check("R10", colOut, 100);
    cycle(0, 0, 0, 0, 0);

    // R8: inputs changed during a burst are ignored
    cycle(1, 12, 3, 0, 0);
    cycle(0, 300, 1, 1, 0);
    check("R8", colOut, 13);
    cycle(0, 301, 0, 1, 0);
    check("R8", colOut, 14);
    for (int i = 0; i < 6; i++) cycle(0, 255, 7, 1, 0);
    check("R8", colValid, 0);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      bit st, sp;
      st = ($urandom % 8) == 0;
      sp = ($urandom % 16) == 0;
      cycle(st, int'($urandom % PAGE), int'($urandom % 8), bit'($urandom % 2), sp);
    end
    summary();
  end
endmodule